// File: doc/BRIEF.md
# Shift and Rotate Unit for an 8-bit Processor

This unit carries out the eight single-bit shift and rotate operations that an 8-bit processor decodes from the second byte of its bit-manipulation prefix group. It takes the opcode byte, the operand and the current carry flag, and returns the shifted value, a full flag set and a decoded view of the register field. The register field is only decoded here. Operand fetch and write-back belong to the surrounding datapath.

The opcode byte is read as `00 ooo ttt`. The field `ooo` selects the operation. The field `ttt` names the target register, and code 110 stands for the memory operand addressed through the pointer pair. All eight operation codes are implemented, including code 110. That code shifts left like the arithmetic left shift, but it forces a 1 into bit 0 instead of a 0. Results are registered, so they appear one clock after the request is accepted.

Top module: `shift_rotate_unit`

## Requirements
- R1: When `in_valid` is 1 and `op_byte[7:6]` is 00, `out_valid` is 1 in the next cycle. The result, flags, `reg_sel` and `mem_sel` for that request are valid in that same cycle. In any other cycle `out_valid` is 0 in the next cycle.
- R2: Operation code 000 rotates left: the result is {a[6:0],a[7]} and carry is a[7]. Code 001 rotates right: the result is {a[0],a[7:1]} and carry is a[0].
- R3: Code 010 rotates left through carry: the result is {a[6:0],cin} and carry is a[7]. Code 011 rotates right through carry: the result is {cin,a[7:1]} and carry is a[0].
- R4: Code 100 gives {a[6:0],0} with carry a[7]. Code 101 gives {a[7],a[7:1]} with carry a[0]. Code 111 gives {0,a[7:1]} with carry a[0].
- R5: Code 110 gives {a[6:0],1} with carry a[7].
- R6: Flags follow the result:
  - `flag_sign` is result bit 7.
  - `flag_zero` is 1 when the result is 0.
  - `flag_parity` is 1 when the result has an even number of ones.
  - `flag_half` and `flag_sub` are 0.
- R7: `reg_sel` equals `op_byte[2:0]`. `mem_sel` is 1 exactly when that field is 110.
- R8: While `rst_n` is low, `out_valid` and every other output are 0.
- R9: A request whose `op_byte[7:6]` is not 00 is ignored. After it, `out_valid` is 0 and `result`, the flags, `reg_sel` and `mem_sel` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_byte | input | 8 | Second opcode byte: group, operation, target |
| operand | input | 8 | Value to shift or rotate |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe, one cycle after acceptance |
| result | output | 8 | Shifted or rotated value |
| flag_sign | output | 1 | Bit 7 of result |
| flag_zero | output | 1 | Result is zero |
| flag_half | output | 1 | Half carry, always 0 |
| flag_parity | output | 1 | Even parity of result |
| flag_sub | output | 1 | Subtract flag, always 0 |
| flag_carry | output | 1 | Bit shifted out |
| reg_sel | output | 3 | Target register field |
| mem_sel | output | 1 | Target is the memory operand |

## Verification
Every output of an accepted request is due exactly one rising edge after the edge at which the request is presented. The driver presents inputs at the falling edge and pushes the expected item into a queue. The monitor pops one item 2 ns after each following rising edge, so it samples the register output once it has settled. Rejected opcodes push no item. For those, the bench samples 2 ns after the next rising edge that `out_valid` is low and that every other output still holds the last accepted value.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int DATA_W  = 8;
    localparam int FIELD_W = 3;
    localparam int GROUP_W = DATA_W - 2 * FIELD_W;
    localparam logic [FIELD_W-1:0] MEM_CODE = 3'b110;
    localparam logic [GROUP_W-1:0] GROUP_CODE = '0;

    typedef enum logic [FIELD_W-1:0] {
        OP_ROT_L      = 3'd0,
        OP_ROT_R      = 3'd1,
        OP_RCY_L      = 3'd2,
        OP_RCY_R      = 3'd3,
        OP_SHL_ARITH  = 3'd4,
        OP_SHR_ARITH  = 3'd5,
        OP_SHL_ONE    = 3'd6,
        OP_SHR_LOGIC  = 3'd7
    } sr_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic half;
        logic parity;
        logic sub;
        logic carry;
    } sr_flags_t;

    typedef struct packed {
        logic               valid;
        logic [DATA_W-1:0]  result;
        sr_flags_t          flags;
        logic [FIELD_W-1:0] reg_sel;
        logic               mem_sel;
    } sr_out_t;
endpackage

// File: rtl/srp_decode.sv
module srp_decode
    import srp_pkg::*;
(
    input  logic [DATA_W-1:0]  op_byte,
    output logic               group_hit,
    output sr_op_e             op,
    output logic [FIELD_W-1:0] reg_sel,
    output logic               mem_sel
);
    always_comb begin
        group_hit = (op_byte[DATA_W-1 -: GROUP_W] == GROUP_CODE);
        op        = sr_op_e'(op_byte[2*FIELD_W-1 -: FIELD_W]);
        reg_sel   = op_byte[FIELD_W-1:0];
        mem_sel   = (op_byte[FIELD_W-1:0] == MEM_CODE);
    end
endmodule

// File: rtl/srp_core.sv
module srp_core
    import srp_pkg::*;
(
    input  sr_op_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        res  = '0;
        cout = 1'b0;
        unique case (op)
            OP_ROT_L:     begin res = {a[MSB-1:0], a[MSB]};  cout = a[MSB]; end
            OP_ROT_R:     begin res = {a[0], a[MSB:1]};      cout = a[0];   end
            OP_RCY_L:     begin res = {a[MSB-1:0], cin};     cout = a[MSB]; end
            OP_RCY_R:     begin res = {cin, a[MSB:1]};       cout = a[0];   end
            OP_SHL_ARITH: begin res = {a[MSB-1:0], 1'b0};    cout = a[MSB]; end
            OP_SHR_ARITH: begin res = {a[MSB], a[MSB:1]};    cout = a[0];   end
            OP_SHL_ONE:   begin res = {a[MSB-1:0], 1'b1};    cout = a[MSB]; end
            OP_SHR_LOGIC: begin res = {1'b0, a[MSB:1]};      cout = a[0];   end
            default:      begin res = '0;                    cout = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/srp_flags.sv
module srp_flags
    import srp_pkg::*;
(
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    output sr_flags_t         flags
);
    always_comb begin
        flags.sign   = res[DATA_W-1];
        flags.zero   = (res == '0);
        flags.half   = 1'b0;
        flags.parity = ~^res;
        flags.sub    = 1'b0;
        flags.carry  = cout;
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import srp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  op_byte,
    input  logic [DATA_W-1:0]  operand,
    input  logic               carry_in,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic               flag_sign,
    output logic               flag_zero,
    output logic               flag_half,
    output logic               flag_parity,
    output logic               flag_sub,
    output logic               flag_carry,
    output logic [FIELD_W-1:0] reg_sel,
    output logic               mem_sel
);
    logic               group_hit;
    sr_op_e             op;
    logic [FIELD_W-1:0] dec_reg;
    logic               dec_mem;
    logic [DATA_W-1:0]  core_res;
    logic               core_cout;
    sr_flags_t          core_flags;
    sr_out_t            out_d, out_q;

    srp_decode u_decode (
        .op_byte   (op_byte),
        .group_hit (group_hit),
        .op        (op),
        .reg_sel   (dec_reg),
        .mem_sel   (dec_mem)
    );

    srp_core u_core (
        .op   (op),
        .a    (operand),
        .cin  (carry_in),
        .res  (core_res),
        .cout (core_cout)
    );

    srp_flags u_flags (
        .res   (core_res),
        .cout  (core_cout),
        .flags (core_flags)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (in_valid && group_hit) begin
            out_d.valid   = 1'b1;
            out_d.result  = core_res;
            out_d.flags   = core_flags;
            out_d.reg_sel = dec_reg;
            out_d.mem_sel = dec_mem;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid   = out_q.valid;
    assign result      = out_q.result;
    assign flag_sign   = out_q.flags.sign;
    assign flag_zero   = out_q.flags.zero;
    assign flag_half   = out_q.flags.half;
    assign flag_parity = out_q.flags.parity;
    assign flag_sub    = out_q.flags.sub;
    assign flag_carry  = out_q.flags.carry;
    assign reg_sel     = out_q.reg_sel;
    assign mem_sel     = out_q.mem_sel;

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_byte[DATA_W-1 -: GROUP_W] == GROUP_CODE) |=> out_valid);

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || op_byte[DATA_W-1 -: GROUP_W] != GROUP_CODE)
            |=> (!out_valid && $stable(result) && $stable(reg_sel) && $stable(flag_carry)));

    p_left_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_byte[DATA_W-1 -: GROUP_W] == GROUP_CODE && !op_byte[FIELD_W])
            |=> (flag_carry == $past(operand[DATA_W-1])));

    p_right_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_byte[DATA_W-1 -: GROUP_W] == GROUP_CODE && op_byte[FIELD_W])
            |=> (flag_carry == $past(operand[0])));

    p_set_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_byte == {GROUP_CODE, OP_SHL_ONE, op_byte[FIELD_W-1:0]})
            |=> (result[0] && result[DATA_W-1:1] == $past(operand[DATA_W-2:0])));

    p_fixed_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!flag_half && !flag_sub));

    p_mem_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_byte[DATA_W-1 -: GROUP_W] == GROUP_CODE)
            |=> (mem_sel == ($past(op_byte[FIELD_W-1:0]) == MEM_CODE)));
endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] op_byte = '0;
    logic [7:0] operand = '0;
    logic       carry_in = 1'b0;
    logic       out_valid;
    logic [7:0] result;
    logic       flag_sign, flag_zero, flag_half, flag_parity, flag_sub, flag_carry;
    logic [2:0] reg_sel;
    logic       mem_sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic       s, z, p, c;
        logic [2:0] sel;
        logic       mem;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t last;

    always #4 clk = ~clk;

    shift_rotate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_byte(op_byte),
        .operand(operand), .carry_in(carry_in), .out_valid(out_valid),
        .result(result), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .flag_half(flag_half), .flag_parity(flag_parity), .flag_sub(flag_sub),
        .flag_carry(flag_carry), .reg_sel(reg_sel), .mem_sel(mem_sel)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [2:0] code, input logic [7:0] a,
                                   input logic cin, input logic [2:0] tgt);
        exp_t e;
        case (code)
            3'd0: begin e.res = {a[6:0], a[7]}; e.c = a[7]; e.tag = "R2"; end
            3'd1: begin e.res = {a[0], a[7:1]}; e.c = a[0]; e.tag = "R2"; end
            3'd2: begin e.res = {a[6:0], cin};  e.c = a[7]; e.tag = "R3"; end
            3'd3: begin e.res = {cin, a[7:1]};  e.c = a[0]; e.tag = "R3"; end
            3'd4: begin e.res = {a[6:0], 1'b0}; e.c = a[7]; e.tag = "R4"; end
            3'd5: begin e.res = {a[7], a[7:1]}; e.c = a[0]; e.tag = "R4"; end
            3'd6: begin e.res = {a[6:0], 1'b1}; e.c = a[7]; e.tag = "R5"; end
            default: begin e.res = {1'b0, a[7:1]}; e.c = a[0]; e.tag = "R4"; end
        endcase
        e.s = e.res[7];
        e.z = (e.res == 8'h00);
        e.p = ($countones(e.res) % 2 == 0);
        e.sel = tgt;
        e.mem = (tgt == 3'd6);
        return e;
    endfunction

    task automatic drive(input logic [2:0] code, input logic [2:0] tgt,
                         input logic [7:0] a, input logic cin);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        op_byte  = {2'b00, code, tgt};
        operand  = a;
        carry_in = cin;
        e = model(code, a, cin, tgt);
        q.push_back(e);
        last = e;
    endtask

    // Monitor: results are due one rising edge after the request.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(out_valid === 1'b1, "R1", "out_valid", {7'd0, out_valid}, 8'h01);
                chk(result === e.res, e.tag, "result", result, e.res);
                chk(flag_carry === e.c, e.tag, "carry", {7'd0, flag_carry}, {7'd0, e.c});
                chk({flag_sign, flag_zero, flag_parity, flag_half, flag_sub} ===
                    {e.s, e.z, e.p, 2'b00}, "R6", "flags S,Z,P,H,N",
                    {3'd0, flag_sign, flag_zero, flag_parity, flag_half, flag_sub},
                    {3'd0, e.s, e.z, e.p, 2'b00});
                chk({reg_sel, mem_sel} === {e.sel, e.mem}, "R7", "reg_sel,mem_sel",
                    {4'd0, reg_sel, mem_sel}, {4'd0, e.sel, e.mem});
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R8: outputs cleared while reset is held
        repeat (3) @(posedge clk);
        #2;
        chk({out_valid, result, flag_sign, flag_zero, flag_half, flag_parity,
             flag_sub, flag_carry, reg_sel, mem_sel} === '0, "R8", "reset outputs",
            result, 8'h00);
        chk(out_valid === 1'b0, "R8", "reset out_valid", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners: zero result, carry chain, set-one slot
        drive(3'd4, 3'd0, 8'h80, 1'b0);   // R4 result 00, zero and parity set
        drive(3'd6, 3'd6, 8'h80, 1'b0);   // R5 result 01, memory target
        drive(3'd2, 3'd1, 8'h00, 1'b1);   // R3 carry shifted in
        drive(3'd5, 3'd7, 8'h81, 1'b0);   // R4 sign kept
        drive(3'd7, 3'd7, 8'h81, 1'b1);   // R4 logic right ignores cin

        // Exhaustive sweep: every code, every operand, both carry values
        for (int code = 0; code < 8; code++)
            for (int cin = 0; cin < 2; cin++)
                for (int a = 0; a < 256; a++)
                    drive(code[2:0], a[2:0] ^ code[2:0], a[7:0], cin[0]);

        // R9: each non-zero group code is ignored and outputs hold
        for (int g = 1; g < 4; g++) begin
            drive(3'd0, 3'd3, 8'hA5, 1'b0);
            @(negedge clk);
            in_valid = 1'b1;
            op_byte  = {g[1:0], 3'd6, 3'd6};
            operand  = 8'h3C;
            carry_in = 1'b1;
            @(posedge clk);
            #2;
            chk(out_valid === 1'b0, "R9", "out_valid after ignored op",
                {7'd0, out_valid}, 8'h00);
            chk(result === last.res && reg_sel === last.sel && mem_sel === last.mem &&
                flag_carry === last.c, "R9", "held result", result, last.res);
        end

        // R1: idle cycle leaves out_valid low
        @(negedge clk);
        in_valid = 1'b0;
        op_byte  = 8'h06;
        @(posedge clk);
        #2;
        chk(out_valid === 1'b0, "R1", "idle out_valid", {7'd0, out_valid}, 8'h00);

        repeat (3) @(posedge clk);
        #1;
        chk(q.size() == 0, "R1", "results outstanding", q.size(), 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule